// File: doc/BRIEF.md
# Multi-Clock Frequency Counter Bank

This block measures the frequencies of several unrelated clocks against the system clock. The measurement window is shared. One counter counts system clock cycles while the window is open. One counter per measured clock counts that clock's cycles over the same interval. Software can then scale each measured count against the system count to obtain a frequency. The block does not perform that division.

The window can be gated in two ways:
- **Software mode:** the window opens when the control register is written with its enable bit set. It closes when the control register is written with that bit cleared.
- **Pulse-timed mode:** software arms the block. The next rising edge of an external once-per-second pulse opens the window, and the following rising edge closes it.

After the window closes, a fixed settle delay lets the frozen counts cross back into the system domain. A done flag then marks the counts as valid. The enable level reaches each measured domain through a two-flop synchronizer. Each count returns to the system domain as a Gray-coded value.

Top module: `freqMeter`

## Requirements
- R1: After reset, the control, status, reference count and every measured count read as zero.
- R2: Register offsets are word addresses: 0 control, 1 status, 2 reference count, and 3+k for measured clock k. In software mode (control bit1 = 0), a control write with bit0 = 1 opens the window. A later control write with bit0 = 0 closes it. The reference count then equals the number of system clock edges from the opening write's sampling edge to the closing write's sampling edge.
- R3: Status bit0 (busy) is 1 while the window is open and for SETTLE_CYCLES system cycles after it closes. Status bit1 (done) then becomes 1 and stays 1 until the next window opens. Busy and done are never both 1.
- R4: With done set, each measured count equals the measured clock's period count over the window duration, within ±3.
- R5: While done stays set, the reference and measured counts do not change.
- R6: Each counter saturates at all-ones instead of wrapping. Status bit2 (reference) and status bit 3+k (measured clock k) are sticky overflow flags. Each flag is set when its counter would have passed all-ones, and cleared when the next window opens.
- R7: With control bit1 = 1 and bit2 (arm) = 1 written while idle, the next pulse rising edge opens the window and the following one closes it. A rising edge on the pulse input opens the window at the third system edge that samples the input high. The arm bit (control readback bit2) clears when the window opens. The reference count then equals the pulse period in system cycles.
- R8: In pulse-timed mode without arm, pulse edges open no window and leave busy, done and the counts unchanged.
- R9: Control writes made while busy have no effect on mode or arm. The only exception is a software-mode write with bit0 = 0 while the window is open, which closes it. In pulse-timed mode, a write cannot close an open window. Control readback shows bit0 = last accepted enable, bit1 = mode, bit2 = armed.
- R10: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock, nominally 100 MHz |
| rstN | input | 1 | Active-low asynchronous reset for all domains |
| measClk | input | NUM_CLK | Clocks being measured, one bit each |
| ppsIn | input | 1 | Once-per-second timing pulse, asynchronous |
| regAddr | input | ADDR_W | Register word offset |
| regWrEn | input | 1 | Write strobe; only the control register is writable |
| regWrData | input | 3 | Control write data: bit0 enable, bit1 mode, bit2 arm |
| regRdData | output | 32 | Combinational read data for regAddr |

## Verification
The assertions assume the following:
- The settle delay covers the crossing latency back from the slowest measured clock. This means about three of its cycles plus two system cycles. Under that assumption, counts are frozen whenever done is held.
- Pulse edges are never coincident with a control write.
- Pulse edges stay high for at least two system cycles.

The stimulus keeps within these assumptions:
- The two measured clocks run at 6.4 ns and 13 ns periods, well inside the 16-cycle settle delay.
- Each pulse stays high for three system cycles.
- Writes and pulse edges are placed hundreds of cycles apart.

// File: rtl/fmPkg.sv
package fmPkg;
  localparam int REG_W = 32;
  localparam int CTRL_W = 3;
  localparam int CTRL_EN = 0;
  localparam int CTRL_MODE = 1;
  localparam int CTRL_ARM = 2;
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_REF = 2;
  localparam int OFS_MEAS = 3;

  typedef enum logic [1:0] {WIN_IDLE, WIN_OPEN, WIN_SETTLE} winState_t;

  typedef struct packed {
    logic window;
    logic open;
  } fmStrobe_t;
endpackage

// File: rtl/fmClkCounter.sv
module fmClkCounter #(
  parameter int CNT_W = 32
) (
  input  logic             measClk,
  input  logic             sysClk,
  input  logic             rstN,
  input  logic             window,
  output logic [CNT_W-1:0] countSys,
  output logic             ovfSys
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0] measRst;
  logic measRstN;
  always_ff @(posedge measClk or negedge rstN) begin
    if (!rstN) measRst <= '0;
    else       measRst <= {measRst[0], 1'b1};
  end
  assign measRstN = measRst[1];

  logic [1:0] enSync;
  logic enPrev;
  logic localEn;
  logic localRise;
  logic [CNT_W-1:0] cnt;
  logic ovf;
  logic [CNT_W-1:0] grayQ;
  logic ovfQ;

  assign localEn = enSync[1];
  assign localRise = localEn & ~enPrev;

  always_ff @(posedge measClk or negedge measRstN) begin
    if (!measRstN) begin
      enSync <= '0;
      enPrev <= 1'b0;
      cnt    <= '0;
      ovf    <= 1'b0;
      grayQ  <= '0;
      ovfQ   <= 1'b0;
    end else begin
      enSync <= {enSync[0], window};
      enPrev <= localEn;
      if (localRise) begin
        cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
        ovf <= 1'b0;
      end else if (localEn) begin
        if (cnt == CNT_MAX) ovf <= 1'b1;
        else                cnt <= cnt + 1'b1;
      end
      grayQ <= cnt ^ (cnt >> 1);
      ovfQ  <= ovf;
    end
  end

  logic [CNT_W-1:0] graySync1, graySync2;
  logic ovfSync1, ovfSync2;
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      graySync1 <= '0;
      graySync2 <= '0;
      ovfSync1  <= 1'b0;
      ovfSync2  <= 1'b0;
    end else begin
      graySync1 <= grayQ;
      graySync2 <= graySync1;
      ovfSync1  <= ovfQ;
      ovfSync2  <= ovfSync1;
    end
  end

  always_comb begin
    for (int i = 0; i < CNT_W; i++) countSys[i] = ^(graySync2 >> i);
  end
  assign ovfSys = ovfSync2;

  // R6
  meas_sat_hold_chk: assert property (@(posedge measClk) disable iff (!measRstN)
    (localEn && !localRise && cnt == CNT_MAX) |=> cnt == CNT_MAX);
  // R6
  meas_ovf_sticky_chk: assert property (@(posedge measClk) disable iff (!measRstN)
    (ovf && !localRise) |=> ovf);
endmodule

// File: rtl/fmCountPath.sv
module fmCountPath import fmPkg::*; #(
  parameter int NUM_CLK = 2,
  parameter int CNT_W = 32
) (
  input  logic                            sysClk,
  input  logic                            rstN,
  input  logic [NUM_CLK-1:0]              measClk,
  input  fmStrobe_t                       strobe,
  output logic [CNT_W-1:0]                refCount,
  output logic                            refOvf,
  output logic [NUM_CLK-1:0][CNT_W-1:0]   measCount,
  output logic [NUM_CLK-1:0]              measOvf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      refCount <= '0;
      refOvf   <= 1'b0;
    end else if (strobe.open) begin
      refCount <= {{(CNT_W-1){1'b0}}, 1'b1};
      refOvf   <= 1'b0;
    end else if (strobe.window) begin
      if (refCount == CNT_MAX) refOvf <= 1'b1;
      else                     refCount <= refCount + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_CLK; k++) begin : gMeas
    fmClkCounter #(.CNT_W(CNT_W)) uCnt (
      .measClk (measClk[k]),
      .sysClk  (sysClk),
      .rstN    (rstN),
      .window  (strobe.window),
      .countSys(measCount[k]),
      .ovfSys  (measOvf[k])
    );
  end

  // R5
  ref_frozen_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (!strobe.window && !strobe.open) |=> $stable(refCount));
  // R6
  ref_sat_hold_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (strobe.window && !strobe.open && refCount == CNT_MAX) |=> (refCount == CNT_MAX && refOvf));
endmodule

// File: rtl/fmWindowCtrl.sv
module fmWindowCtrl import fmPkg::*; #(
  parameter int NUM_CLK = 2,
  parameter int CNT_W = 32,
  parameter int SETTLE_CYCLES = 16,
  parameter int ADDR_W = 4
) (
  input  logic                            sysClk,
  input  logic                            rstN,
  input  logic                            ppsIn,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic                            regWrEn,
  input  logic [CTRL_W-1:0]               regWrData,
  output logic [REG_W-1:0]                regRdData,
  input  logic [CNT_W-1:0]                refCount,
  input  logic                            refOvf,
  input  logic [NUM_CLK-1:0][CNT_W-1:0]   measCount,
  input  logic [NUM_CLK-1:0]              measOvf,
  output fmStrobe_t                       strobe
);
  localparam int SET_W = $clog2(SETTLE_CYCLES);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYCLES - 1);

  winState_t stateQ;
  logic modeQ, enQ, armQ, doneQ, openQ;
  logic [SET_W-1:0] settleCnt;
  logic [2:0] ppsSync;
  logic ppsRise, ctrlWr, busy, window;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) ppsSync <= '0;
    else       ppsSync <= {ppsSync[1:0], ppsIn};
  end
  assign ppsRise = ppsSync[1] & ~ppsSync[2];
  assign ctrlWr = regWrEn && (regAddr == ADDR_W'(OFS_CTRL));
  assign window = (stateQ == WIN_OPEN);
  assign busy = (stateQ != WIN_IDLE);

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= WIN_IDLE;
      modeQ     <= 1'b0;
      enQ       <= 1'b0;
      armQ      <= 1'b0;
      doneQ     <= 1'b0;
      openQ     <= 1'b0;
      settleCnt <= '0;
    end else begin
      openQ <= 1'b0;
      case (stateQ)
        WIN_IDLE: begin
          if (ctrlWr) begin
            modeQ <= regWrData[CTRL_MODE];
            if (!regWrData[CTRL_MODE]) begin
              enQ  <= regWrData[CTRL_EN];
              armQ <= 1'b0;
              if (regWrData[CTRL_EN]) begin
                stateQ <= WIN_OPEN;
                openQ  <= 1'b1;
                doneQ  <= 1'b0;
              end
            end else begin
              enQ  <= 1'b0;
              armQ <= regWrData[CTRL_ARM];
            end
          end else if (modeQ && armQ && ppsRise) begin
            stateQ <= WIN_OPEN;
            openQ  <= 1'b1;
            doneQ  <= 1'b0;
            armQ   <= 1'b0;
          end
        end
        WIN_OPEN: begin
          if ((!modeQ && ctrlWr && !regWrData[CTRL_EN]) || (modeQ && ppsRise)) begin
            stateQ    <= WIN_SETTLE;
            settleCnt <= '0;
            enQ       <= 1'b0;
          end
        end
        WIN_SETTLE: begin
          if (settleCnt == SET_LAST) begin
            stateQ <= WIN_IDLE;
            doneQ  <= 1'b1;
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        default: stateQ <= WIN_IDLE;
      endcase
    end
  end

  assign strobe.window = window;
  assign strobe.open = openQ;

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(OFS_CTRL)) begin
      regRdData[CTRL_EN]   = enQ;
      regRdData[CTRL_MODE] = modeQ;
      regRdData[CTRL_ARM]  = armQ;
    end else if (regAddr == ADDR_W'(OFS_STAT)) begin
      regRdData[0] = busy;
      regRdData[1] = doneQ;
      regRdData[2] = refOvf;
      regRdData[3 +: NUM_CLK] = measOvf;
    end else if (regAddr == ADDR_W'(OFS_REF)) begin
      regRdData = REG_W'(refCount);
    end else begin
      for (int k = 0; k < NUM_CLK; k++)
        if (regAddr == ADDR_W'(OFS_MEAS + k)) regRdData = REG_W'(measCount[k]);
    end
  end

  // R3
  busy_done_excl_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    !(busy && doneQ));
  // R3
  settle_after_close_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    $fell(window) |=> (busy && !doneQ));
  // R5
  frozen_counts_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (doneQ && $past(doneQ)) |-> ($stable(measCount) && $stable(refCount)));
  // R7
  pps_armed_open_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    ($rose(window) && modeQ) |-> $past(armQ));
endmodule

// File: rtl/freqMeter.sv
module freqMeter import fmPkg::*; #(
  parameter int NUM_CLK = 2,
  parameter int CNT_W = 32,
  parameter int SETTLE_CYCLES = 16,
  parameter int ADDR_W = 4
) (
  input  logic              sysClk,
  input  logic              rstN,
  input  logic [NUM_CLK-1:0] measClk,
  input  logic              ppsIn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [2:0]        regWrData,
  output logic [31:0]       regRdData
);
  fmStrobe_t strobe;
  logic [CNT_W-1:0] refCount;
  logic refOvf;
  logic [NUM_CLK-1:0][CNT_W-1:0] measCount;
  logic [NUM_CLK-1:0] measOvf;

  fmWindowCtrl #(.NUM_CLK(NUM_CLK), .CNT_W(CNT_W), .SETTLE_CYCLES(SETTLE_CYCLES), .ADDR_W(ADDR_W)) uCtrl (
    .sysClk   (sysClk),
    .rstN     (rstN),
    .ppsIn    (ppsIn),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .refCount (refCount),
    .refOvf   (refOvf),
    .measCount(measCount),
    .measOvf  (measOvf),
    .strobe   (strobe)
  );

  fmCountPath #(.NUM_CLK(NUM_CLK), .CNT_W(CNT_W)) uPath (
    .sysClk   (sysClk),
    .rstN     (rstN),
    .measClk  (measClk),
    .strobe   (strobe),
    .refCount (refCount),
    .refOvf   (refOvf),
    .measCount(measCount),
    .measOvf  (measOvf)
  );
endmodule

// File: tb/tb_freqMeter.sv
`timescale 1ns/1ps
module tb_freqMeter;
  localparam int NUM_CLK = 2;
  localparam int CNT_W = 12;
  localparam int SETTLE = 16;
  localparam int ADDR_W = 4;
  localparam int CMAX = (1 << CNT_W) - 1;
  localparam real TSYS = 10.0;
  localparam real TM0 = 6.4;
  localparam real TM1 = 13.0;

  logic sysClk = 0, rstN = 0, ppsIn = 0, regWrEn = 0;
  logic mclkA = 0, mclkB = 0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [2:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NUM_CLK-1:0] measClk;

  always #5 sysClk = ~sysClk;
  always #3.2 mclkA = ~mclkA;
  always #6.5 mclkB = ~mclkB;
  assign measClk = {mclkB, mclkA};

  freqMeter #(.NUM_CLK(NUM_CLK), .CNT_W(CNT_W), .SETTLE_CYCLES(SETTLE), .ADDR_W(ADDR_W)) dut (
    .sysClk(sysClk), .rstN(rstN), .measClk(measClk), .ppsIn(ppsIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData));

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic checkNear(string tag, longint got, real ideal);
    real lim;
    lim = (ideal > CMAX) ? CMAX : ideal;
    checks++;
    if (got < lim - 3.0 || got > lim + 3.0) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d(+-3)", tag, got, longint'(lim));
    end
  endtask

  // behavioural model, updated on every system edge
  int edgeNo = 0, ppsFire = -1, openEdge = 0, closeEdge = 0, mSettle = 0;
  bit mWin = 0, mDone = 0, mMode = 0, mEn = 0, mArm = 0, everOpen = 0, ppsPrev = 0;

  always @(posedge sysClk) begin
    if (!rstN) begin
      mWin = 0; mDone = 0; mMode = 0; mEn = 0; mArm = 0; mSettle = 0; ppsPrev = 0; ppsFire = -1;
    end else begin
      bit evt, wr;
      edgeNo++;
      evt = (ppsFire == edgeNo);
      if (ppsIn && !ppsPrev) ppsFire = edgeNo + 2;
      ppsPrev = ppsIn;
      wr = regWrEn && regAddr == 0;
      if (mSettle > 0) begin
        mSettle--;
        if (mSettle == 0) mDone = 1;
      end else if (mWin) begin
        if ((!mMode && wr && !regWrData[0]) || (mMode && evt)) begin
          mWin = 0; mEn = 0; mSettle = SETTLE; closeEdge = edgeNo;
        end
      end else if (wr) begin
        mMode = regWrData[1];
        if (!mMode) begin
          mEn = regWrData[0]; mArm = 0;
          if (mEn) begin mWin = 1; mDone = 0; openEdge = edgeNo; everOpen = 1; end
        end else begin
          mEn = 0; mArm = regWrData[2];
        end
      end else if (mMode && mArm && evt) begin
        mWin = 1; mDone = 0; mArm = 0; openEdge = edgeNo; everOpen = 1;
      end
    end
  end

  // per-clock comparison of the presented register against the model
  always @(negedge sysClk) begin
    if (rstN && !finished) begin
      bit busy;
      int span;
      busy = mWin || (mSettle > 0);
      span = closeEdge - openEdge;
      case (regAddr)
        4'd0: check("R9 ctrl readback", regRdData, {mArm, mMode, mEn});
        4'd1: begin
          check("R3 busy/done", regRdData[1:0], {mDone, busy});
          if (!everOpen) check("R1 status ovf", regRdData[4:2], 0);
          else if (mDone) check("R6 ref ovf", regRdData[2], span > CMAX);
        end
        4'd2: begin
          if (!everOpen) check("R1 ref", regRdData, 0);
          else if (!busy) check("R2 ref count", regRdData, (span > CMAX) ? CMAX : span);
        end
        4'd3: begin
          if (!everOpen) check("R1 meas0", regRdData, 0);
          else if (mDone) checkNear("R4 meas0", regRdData, span * TSYS / TM0);
        end
        4'd4: begin
          if (!everOpen) check("R1 meas1", regRdData, 0);
          else if (mDone) checkNear("R4 meas1", regRdData, span * TSYS / TM1);
        end
        default: check("R10 unmapped", regRdData, 0);
      endcase
    end
  end

  task automatic cyc();
    @(posedge sysClk); #1;
  endtask

  task automatic wrCtrl(logic [2:0] d);
    cyc(); regAddr = 0; regWrEn = 1; regWrData = d;
    cyc(); regWrEn = 0;
  endtask

  task automatic readReg(int a, output logic [31:0] v);
    cyc(); regAddr = ADDR_W'(a);
    @(negedge sysClk); v = regRdData;
  endtask

  task automatic swWindow(int n);
    wrCtrl(3'b001);
    repeat (n - 2) cyc();
    wrCtrl(3'b000);
  endtask

  task automatic ppsPulse();
    cyc(); ppsIn = 1;
    repeat (3) cyc();
    ppsIn = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge sysClk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (5) cyc();
    rstN = 1;
    repeat (3) cyc();
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      readReg(a, v);
      check("R1 reset readback", v, 0);
    end

    // R2/R3/R4/R5 software window of 300 cycles
    swWindow(300);
    readReg(1, v);
    check("R3 busy during settle", v, 1);
    repeat (SETTLE) cyc();
    readReg(1, v);
    check("R3 done after settle", v, 2);
    readReg(2, v);
    check("R2 ref count 300", v, 300);
    readReg(3, v);
    checkNear("R4 meas0 300", v, 300 * TSYS / TM0);
    repeat (20) cyc();
    readReg(3, v2);
    check("R5 meas0 frozen", v2, v);
    readReg(4, v);
    checkNear("R4 meas1 300", v, 300 * TSYS / TM1);

    // R9 mode change ignored while open
    wrCtrl(3'b001);
    repeat (50) cyc();
    wrCtrl(3'b011);
    readReg(0, v);
    check("R9 mode write ignored while busy", v, 1);
    repeat (100) cyc();
    wrCtrl(3'b000);
    repeat (SETTLE + 2) cyc();

    // R6 saturation and sticky overflow
    swWindow(5000);
    repeat (SETTLE + 2) cyc();
    readReg(2, v);
    check("R6 ref saturates", v, CMAX);
    readReg(3, v);
    check("R6 meas0 saturates", v, CMAX);
    readReg(1, v);
    check("R6 overflow flags", v, 32'hE);
    swWindow(100);
    repeat (SETTLE + 2) cyc();
    readReg(1, v);
    check("R6 overflow cleared on reopen", v, 2);

    // R8 pulses without arm
    wrCtrl(3'b010);
    ppsPulse();
    repeat (10) cyc();
    readReg(1, v);
    check("R8 unarmed pulse ignored status", v, 2);
    readReg(2, v);
    check("R8 unarmed pulse ignored ref", v, 100);

    // R7 armed pulse-timed window of 800 cycles
    wrCtrl(3'b110);
    readReg(0, v);
    check("R7 armed readback", v, 6);
    ppsPulse();
    repeat (100) cyc();
    wrCtrl(3'b010);
    readReg(1, v);
    check("R9 write cannot close pulse window", v[0], 1);
    repeat (693) cyc();
    ppsPulse();
    repeat (SETTLE + 4) cyc();
    readReg(2, v);
    check("R7 ref equals pulse period", v, 800);
    readReg(0, v);
    check("R7 arm cleared on open", v, 2);
    readReg(3, v);
    checkNear("R7 meas0 pulse window", v, 800 * TSYS / TM0);
    ppsPulse();
    repeat (10) cyc();
    readReg(1, v);
    check("R7 no reopen without rearm", v, 2);

    // R10 unmapped offsets
    readReg(7, v);
    check("R10 offset 7", v, 0);
    readReg(15, v);
    check("R10 offset 15", v, 0);

    summary();
  end
endmodule